// File: doc/BRIEF.md
# Cache-Line Fetch Group Extractor

This block turns one instruction-cache line and the current fetch PC into a group of up to `W` instructions for the decode stage. Extraction begins at the word that the PC points to inside the line. It walks forward one word at a time and stops at the first of three events: the last word of the line, a full group of `W` slots, or a control instruction that the branch predictor marks as taken. A taken branch is still placed in the group, and the fetch PC is then steered to its predicted target.

For every slot the block reports the instruction word, its PC, a sequence number from a free-running counter, and the predicted successor PC. It also produces the line-aligned request address for the cache and the PC and next-PC for the following fetch cycle. The branch predictor is reached through one combinational query port per slot. The predictor's contents and the decode logic are outside this block. Group results are registered one clock after a valid line is presented.

Top module: `fgx_top`

## Requirements
- R1: `req_addr` equals `fetch_pc` with its low log2(`LINE_BYTES`) bits forced to zero. It is combinational.
- R2: Slot 0 holds the word at byte offset `fetch_pc & (LINE_BYTES-1)`, and `slot_pc` of slot 0 equals `fetch_pc`. Word i of the line is `line_data[32*i+31 : 32*i]` (little-endian: the lowest-addressed byte sits in the lowest bits). `line_is_ctrl[i]` marks word i as a control instruction.
- R3: Slot k+1 holds the word after slot k, with a PC 4 higher. The group never crosses the end of the line.
- R4: A group has at most `W` slots. `slot_valid` is filled from bit 0 upward with no gaps, and `grp_count` equals the number of valid slots.
- R5: A control instruction in slot k with `bp_taken[k]`=1 is the last slot of the group. Its `slot_tgt` is `bp_target[k]`, and `pc_out` becomes that target.
- R6: A non-control slot, or a control slot predicted not taken, has `slot_tgt` = its PC + 4. `bp_taken` has no effect on non-control slots. When the last slot is not a taken branch, `pc_out` is the last slot's PC + 4.
- R7: Valid slots carry consecutive sequence numbers, beginning at the counter value. After each group the counter advances by `grp_count`, so numbering continues across groups.
- R8: `npc_out` always equals `pc_out` + 4.
- R9: Results appear on the clock edge that samples `line_valid`=1. After an edge with `line_valid`=0, `grp_valid`=0, `grp_count`=0 and `slot_valid`=0, while `pc_out` and the sequence counter keep their values.
- R10: Reset clears `grp_valid`, `grp_count`, `slot_valid` and the sequence counter, sets `pc_out` to 0 and `npc_out` to 4, and a later group restarts numbering at 0.
- R11: `bp_qry_valid[k]` is 1 exactly when slot k belongs to the group being formed and holds a control instruction. `bp_qry_pc[k]` is that slot's PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line and PC are valid this cycle |
| line_data | input | LINE_BYTES*8 | Cache line, little-endian words |
| line_is_ctrl | input | LINE_BYTES/4 | Per-word control-instruction flag |
| fetch_pc | input | AW | Current fetch PC (word aligned) |
| req_addr | output | AW | Line-aligned cache request address |
| bp_qry_valid | output | W | Predictor query per slot |
| bp_qry_pc | output | W*AW | PC queried per slot |
| bp_taken | input | W | Predictor taken answer per slot |
| bp_target | input | W*AW | Predictor target per slot |
| grp_valid | output | 1 | Group registered this cycle |
| grp_count | output | $clog2(W+1) | Number of valid slots |
| slot_valid | output | W | Per-slot valid |
| slot_insn | output | W*32 | Per-slot instruction word |
| slot_pc | output | W*AW | Per-slot PC |
| slot_seq | output | W*SEQW | Per-slot sequence number |
| slot_tgt | output | W*AW | Per-slot predicted successor PC |
| pc_out | output | AW | Next fetch PC |
| npc_out | output | AW | Next fetch PC + 4 |

## Verification
The bench uses several start offsets. A PC at offset 0 separates the width limit from the line limit. Offsets near the top of the line make the line end cut the group short at one, two or three slots. Taken branches are placed in slot 0, in a middle slot, in the last slot of a full group and on the last word of the line, and each placement checks that the group ends at that slot and that the PC is redirected. A not-taken branch placed ahead of a taken one, together with `bp_taken` held high on lines that have no control words, confirms that only control instructions predicted taken end a group. Idle cycles between groups and a reset in the middle of the run test that sequence numbering continues across groups and restarts at zero after reset.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
  localparam int unsigned FGX_INSN_BYTES = 4;
  localparam int unsigned FGX_INSN_BITS  = 32;
endpackage

// File: rtl/fgx_slot.sv
module fgx_slot
  import fgx_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned AW         = 32,
  parameter int unsigned K          = 0
) (
  input  logic [LINE_BYTES*8-1:0]                  line_data,
  input  logic [LINE_BYTES/FGX_INSN_BYTES-1:0]     line_is_ctrl,
  input  logic [AW-1:0]                            fetch_pc,
  output logic                                     in_line,
  output logic                                     ctrl,
  output logic [FGX_INSN_BITS-1:0]                 insn,
  output logic [AW-1:0]                            pc
);
  localparam int unsigned LINE_WORDS = LINE_BYTES / FGX_INSN_BYTES;
  localparam int unsigned OFFW       = $clog2(LINE_BYTES);
  localparam int unsigned WIDXW      = $clog2(LINE_WORDS);
  localparam int unsigned SUBW       = $clog2(FGX_INSN_BYTES);

  logic [WIDXW:0]   idx;
  logic [WIDXW-1:0] widx;

  // word index of this slot, one bit wider so running off the line is visible
  assign idx     = {1'b0, fetch_pc[OFFW-1:SUBW]} + (WIDXW+1)'(K);
  assign in_line = ~idx[WIDXW];
  assign widx    = idx[WIDXW-1:0];
  assign insn    = line_data[widx*FGX_INSN_BITS +: FGX_INSN_BITS];
  assign ctrl    = in_line & line_is_ctrl[widx];
  assign pc      = fetch_pc + AW'(K * FGX_INSN_BYTES);
endmodule

// File: rtl/fgx_top.sv
module fgx_top
  import fgx_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned W          = 4,
  parameter int unsigned AW         = 32,
  parameter int unsigned SEQW       = 16,
  localparam int unsigned LINE_WORDS = LINE_BYTES / FGX_INSN_BYTES,
  localparam int unsigned CNTW       = $clog2(W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_valid,
  input  logic [LINE_BYTES*8-1:0]       line_data,
  input  logic [LINE_WORDS-1:0]         line_is_ctrl,
  input  logic [AW-1:0]                 fetch_pc,
  output logic [AW-1:0]                 req_addr,
  output logic [W-1:0]                  bp_qry_valid,
  output logic [W*AW-1:0]               bp_qry_pc,
  input  logic [W-1:0]                  bp_taken,
  input  logic [W*AW-1:0]               bp_target,
  output logic                          grp_valid,
  output logic [CNTW-1:0]               grp_count,
  output logic [W-1:0]                  slot_valid,
  output logic [W*FGX_INSN_BITS-1:0]    slot_insn,
  output logic [W*AW-1:0]               slot_pc,
  output logic [W*SEQW-1:0]             slot_seq,
  output logic [W*AW-1:0]               slot_tgt,
  output logic [AW-1:0]                 pc_out,
  output logic [AW-1:0]                 npc_out
);
  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);

  function automatic logic [AW-1:0] pc_after(input logic [AW-1:0] p);
    return p + AW'(FGX_INSN_BYTES);
  endfunction

  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] p);
    return p & ~LINE_MASK;
  endfunction

  // named internal events
  logic [W-1:0]             in_line, ctrl, alive, taken;
  logic [AW-1:0]            pc_s   [W];
  logic [AW-1:0]            succ_s [W];
  logic [FGX_INSN_BITS-1:0] insn_s [W];
  logic [CNTW-1:0]          cnt;
  logic [AW-1:0]            nxt;
  logic [SEQW-1:0]          seq_ctr;

  assign req_addr = line_base(fetch_pc);

  for (genvar k = 0; k < W; k++) begin : g_slot
    fgx_slot #(.LINE_BYTES(LINE_BYTES), .AW(AW), .K(k)) u_slot (
      .line_data    (line_data),
      .line_is_ctrl (line_is_ctrl),
      .fetch_pc     (fetch_pc),
      .in_line      (in_line[k]),
      .ctrl         (ctrl[k]),
      .insn         (insn_s[k]),
      .pc           (pc_s[k])
    );
    assign bp_qry_pc[k*AW +: AW] = pc_s[k];
  end

  // chain: a slot survives if the previous one did, it is inside the line
  // and the previous slot did not end the group with a taken branch
  always_comb begin
    alive  = '0;
    taken  = '0;
    cnt    = '0;
    nxt    = fetch_pc;
    for (int k = 0; k < W; k++) begin
      if (k == 0) alive[k] = line_valid & in_line[k];
      else        alive[k] = alive[k-1] & in_line[k] & ~taken[k-1];
      taken[k]  = alive[k] & ctrl[k] & bp_taken[k];
      succ_s[k] = taken[k] ? bp_target[k*AW +: AW] : pc_after(pc_s[k]);
      if (alive[k]) begin
        cnt = cnt + CNTW'(1);
        nxt = succ_s[k];
      end
    end
    bp_qry_valid = alive & ctrl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid  <= 1'b0;
      grp_count  <= '0;
      slot_valid <= '0;
      slot_insn  <= '0;
      slot_pc    <= '0;
      slot_seq   <= '0;
      slot_tgt   <= '0;
      pc_out     <= '0;
      npc_out    <= AW'(FGX_INSN_BYTES);
      seq_ctr    <= '0;
    end else if (line_valid) begin
      grp_valid  <= 1'b1;
      grp_count  <= cnt;
      slot_valid <= alive;
      for (int k = 0; k < W; k++) begin
        slot_insn[k*FGX_INSN_BITS +: FGX_INSN_BITS] <= insn_s[k];
        slot_pc[k*AW +: AW]                         <= pc_s[k];
        slot_seq[k*SEQW +: SEQW]                    <= seq_ctr + SEQW'(k);
        slot_tgt[k*AW +: AW]                        <= succ_s[k];
      end
      pc_out     <= nxt;
      npc_out    <= pc_after(nxt);
      seq_ctr    <= seq_ctr + SEQW'(cnt);
    end else begin
      grp_valid  <= 1'b0;
      grp_count  <= '0;
      slot_valid <= '0;
    end
  end

  // ---------------- assertions ----------------
  assert_count_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_valid) == grp_count) && (grp_count <= CNTW'(W)));

  assert_npc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    npc_out == pc_out + AW'(FGX_INSN_BYTES));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> (!grp_valid && slot_valid == '0 && $stable(pc_out)));

  assert_query_in_group_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_qry_valid != '0) |-> line_valid);

  assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> slot_valid[0]);

  for (genvar k = 1; k < W; k++) begin : g_chk
    assert_seq_consec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (slot_valid[k-1] &&
        slot_seq[k*SEQW +: SEQW] == slot_seq[(k-1)*SEQW +: SEQW] + SEQW'(1)));

    assert_pc_same_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (slot_pc[k*AW +: AW] == slot_pc[(k-1)*AW +: AW] + AW'(FGX_INSN_BYTES) &&
        line_base(slot_pc[k*AW +: AW]) == line_base(slot_pc[(k-1)*AW +: AW])));

    assert_taken_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> slot_tgt[(k-1)*AW +: AW] == slot_pc[k*AW +: AW]);
  end
endmodule

// File: tb/tb_fgx_top.sv
module tb_fgx_top;
  localparam int CLK_PERIOD = 10;
  localparam int LB   = 64;
  localparam int W    = 4;
  localparam int AW   = 32;
  localparam int SEQW = 16;
  localparam int LW   = LB / 4;
  localparam int CNTW = $clog2(W + 1);
  localparam logic [31:0] BASE = 32'h0001_2340;
  localparam int NV = 11;

  // {off[3:0], ctrl[15:0], taken[3:0], count[2:0], next_pc[31:0]}
  localparam logic [58:0] VEC [NV] = '{
    {4'd0,  16'h0000, 4'b0000, 3'd4, 32'h0001_2350},
    {4'd14, 16'h0000, 4'b0000, 3'd2, 32'h0001_2380},
    {4'd15, 16'h0000, 4'b0000, 3'd1, 32'h0001_2380},
    {4'd2,  16'h0008, 4'b0010, 3'd2, 32'h0000_4100},
    {4'd2,  16'h0008, 4'b0000, 3'd4, 32'h0001_2358},
    {4'd0,  16'h0001, 4'b0001, 3'd1, 32'h0000_4000},
    {4'd13, 16'h8000, 4'b0100, 3'd3, 32'h0000_4200},
    {4'd5,  16'h0140, 4'b1000, 3'd4, 32'h0000_4300},
    {4'd12, 16'h8000, 4'b1000, 3'd4, 32'h0000_4300},
    {4'd4,  16'h0000, 4'b1111, 3'd4, 32'h0001_2360},
    {4'd14, 16'h4000, 4'b0001, 3'd1, 32'h0000_4000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_valid = 1'b0;
  logic [LB*8-1:0] line_data = '0;
  logic [LW-1:0] line_is_ctrl = '0;
  logic [AW-1:0] fetch_pc = '0;
  logic [AW-1:0] req_addr;
  logic [W-1:0] bp_qry_valid;
  logic [W*AW-1:0] bp_qry_pc;
  logic [W-1:0] bp_taken = '0;
  logic [W*AW-1:0] bp_target;
  logic grp_valid;
  logic [CNTW-1:0] grp_count;
  logic [W-1:0] slot_valid;
  logic [W*32-1:0] slot_insn;
  logic [W*AW-1:0] slot_pc;
  logic [W*SEQW-1:0] slot_seq;
  logic [W*AW-1:0] slot_tgt;
  logic [AW-1:0] pc_out, npc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [SEQW-1:0] seq_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < W; k++) begin : g_tgt
    assign bp_target[k*AW +: AW] = 32'h0000_4000 + 32'(k * 256);
  end

  fgx_top dut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
    .line_is_ctrl(line_is_ctrl), .fetch_pc(fetch_pc), .req_addr(req_addr),
    .bp_qry_valid(bp_qry_valid), .bp_qry_pc(bp_qry_pc), .bp_taken(bp_taken),
    .bp_target(bp_target), .grp_valid(grp_valid), .grp_count(grp_count),
    .slot_valid(slot_valid), .slot_insn(slot_insn), .slot_pc(slot_pc),
    .slot_seq(slot_seq), .slot_tgt(slot_tgt), .pc_out(pc_out), .npc_out(npc_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int v, input int i);
    return {16'hC0DE, 8'(v), 8'(i)};
  endfunction

  task automatic run_vec(input int v);
    logic [3:0] off;
    logic [15:0] ctl;
    logic [3:0] tk;
    logic [2:0] cnt;
    logic [31:0] nxt;
    {off, ctl, tk, cnt, nxt} = VEC[v];
    @(negedge clk);
    for (int i = 0; i < LW; i++) line_data[i*32 +: 32] = word_of(v, i);
    line_is_ctrl = ctl;
    bp_taken     = tk;
    fetch_pc     = BASE + 32'(off) * 4;
    line_valid   = 1'b1;
    #1;
    check("R1 req_addr", 64'(req_addr), 64'(BASE));
    for (int k = 0; k < W; k++) begin
      logic exp_q;
      exp_q = (k < int'(cnt)) && ctl[int'(off) + k];
      check("R11 bp_qry_valid", 64'(bp_qry_valid[k]), 64'(exp_q));
      if (exp_q) check("R11 bp_qry_pc", 64'(bp_qry_pc[k*AW +: AW]), 64'(fetch_pc + 32'(4*k)));
    end
    @(negedge clk);
    line_valid   = 1'b0;
    line_data    = '1;
    line_is_ctrl = '1;
    bp_taken     = '1;
    check("R9 grp_valid", 64'(grp_valid), 64'd1);
    check("R4 grp_count", 64'(grp_count), 64'(cnt));
    check("R5/R6 pc_out", 64'(pc_out), 64'(nxt));
    check("R8 npc_out", 64'(npc_out), 64'(nxt + 32'd4));
    for (int k = 0; k < W; k++) begin
      logic [31:0] spc;
      logic [31:0] etgt;
      check("R4 slot_valid", 64'(slot_valid[k]), 64'(k < int'(cnt)));
      if (k < int'(cnt)) begin
        spc  = BASE + 32'(int'(off) + k) * 4;
        etgt = (ctl[int'(off) + k] && tk[k]) ? 32'h0000_4000 + 32'(k * 256) : spc + 32'd4;
        check("R2/R3 slot_insn", 64'(slot_insn[k*32 +: 32]), 64'(word_of(v, int'(off) + k)));
        check("R2/R3 slot_pc", 64'(slot_pc[k*AW +: AW]), 64'(spc));
        check("R7 slot_seq", 64'(slot_seq[k*SEQW +: SEQW]), 64'(seq_model + SEQW'(k)));
        check("R5/R6 slot_tgt", 64'(slot_tgt[k*AW +: AW]), 64'(etgt));
      end
    end
    seq_model = seq_model + SEQW'(cnt);
    @(negedge clk);
    check("R9 idle grp_valid", 64'(grp_valid), 64'd0);
    check("R9 idle slot_valid", 64'(slot_valid), 64'd0);
    check("R9 idle grp_count", 64'(grp_count), 64'd0);
    check("R9 idle pc_out", 64'(pc_out), 64'(nxt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 grp_valid", 64'(grp_valid), 64'd0);
    check("R10 slot_valid", 64'(slot_valid), 64'd0);
    check("R10 grp_count", 64'(grp_count), 64'd0);
    check("R10 pc_out", 64'(pc_out), 64'd0);
    check("R10 npc_out", 64'(npc_out), 64'd4);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_vec(v);

    // longer idle stretch with garbage inputs: counter must not move (R9, R7)
    repeat (4) @(negedge clk);
    check("R9 long idle", 64'(grp_valid), 64'd0);
    run_vec(0);

    // mid-run reset restarts numbering (R10)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset pc_out", 64'(pc_out), 64'd0);
    check("R10 reset npc_out", 64'(npc_out), 64'd4);
    rst_n = 1'b1;
    seq_model = '0;
    run_vec(7);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule